// File: doc/BRIEF.md
# Serial Synthesizer Control Register

This block receives frequency-synthesizer settings over a three-wire serial link made of a serial clock, a serial data line and a load strobe. Bits enter a shift path on each rising edge of the serial clock. When the load strobe rises, the word in the shift path is copied into one of two holding registers. The choice of register comes from a two-bit destination code, which is the last part of the word to arrive.

One holding register keeps the 17-bit reference divide value. The other keeps the comparison-side settings: a 14-bit main count and a 4-bit swallow count. A code that names neither register is rejected, and nothing is written. Every accepted load gives a one-cycle write pulse for the register that was written, so the divider logic downstream can reload.

The three serial pins are asynchronous to the system clock `clk`. Each pin is synchronized with two flops, and edges are then detected in the `clk` domain. The serial clock must therefore stay high for at least three `clk` periods and low for at least three `clk` periods.

Top module: `synth_ser_ctrl`

## Requirements
- R1: While reset is active, and on leaving it, `ref_div`, `main_cnt` and `swal_cnt` are zero and neither `ref_wr` nor `cmp_wr` is high.
- R2: A word is 20 bits, sent most significant bit first. It carries 18 data bits d[17:0], then the destination code a[1] and then a[0]. Each bit is taken on a rising edge of `ser_clk`, and only the last 20 bits before a load count.
- R3: Destination code a[1:0]=2'b11 loads `ref_div` with d[16:0]; d[17] has no effect.
- R4: Destination code 2'b01 loads `main_cnt` with d[17:4] and `swal_cnt` with d[3:0].
- R5: Destination codes 2'b00 and 2'b10 leave all three outputs unchanged and raise no write pulse.
- R6: Each rising edge of `ld_en` with a valid code gives exactly one `clk` cycle of `ref_wr` (code 11) or `cmp_wr` (code 01), even if `ld_en` stays high for a long time. The two pulses are never high together.
- R7: A write to one register leaves the other register unchanged. An output register changes value only in a cycle in which its write pulse is high.
- R8: Registers loaded by a rising edge of `ld_en` show their new value from the third `clk` rising edge after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_dat | input | 1 | Serial data, sampled on rising `ser_clk` |
| ld_en | input | 1 | Load strobe; its rising edge transfers the word |
| ref_div | output | 17 | Reference divide value |
| main_cnt | output | 14 | Comparison-side main count |
| swal_cnt | output | 4 | Comparison-side swallow count |
| ref_wr | output | 1 | One-cycle pulse when `ref_div` is written |
| cmp_wr | output | 1 | One-cycle pulse when `main_cnt`/`swal_cnt` are written |

## Verification
The assertions take two things for granted. First, `ser_dat` is steady around each `ser_clk` rise. Second, the serial pins and `ld_en` stay at each level for several `clk` cycles, so the synchronized data bit can be used at the detected edge and two load events are always apart. The bench keeps to these conditions: it holds every serial phase and every `ld_en` level for at least four `clk` cycles, and it changes data only while `ser_clk` is low. Data values and destination codes are random, and directed cases for all-ones, the ignored leading bit and a long-held strobe are mixed in with them.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    DST_NONE_LO = 2'b00,
    DST_CMP     = 2'b01,
    DST_NONE_HI = 2'b10,
    DST_REF     = 2'b11
  } dst_e;
endpackage

// File: rtl/ssr_edge_sync.sv
module ssr_edge_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] level,
  output logic [W-1:0] rise
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q[i] <= 1'b0;
        s2_q[i] <= 1'b0;
        s3_q[i] <= 1'b0;
      end else begin
        s1_q[i] <= pin_in[i];
        s2_q[i] <= s1_q[i];
        s3_q[i] <= s2_q[i];
      end
    end
    assign level[i] = s2_q[i];
    assign rise[i]  = s2_q[i] & ~s3_q[i];
  end

  for (genvar j = 0; j < W; j++) begin : g_chk
    a_r6_rise_single : assert property (@(posedge clk) disable iff (!rst_n)
      rise[j] |=> !rise[j]);
  end
endmodule

// File: rtl/ssr_shift.sv
module ssr_shift #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  logic [W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (shift_en) word_d = {word_q[W-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word = word_q;

  // R2: newest bit enters at the least significant end, older bits move up
  a_r2_shift_in : assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (word[0] == $past(bit_in)) && (word[W-1:1] == $past(word[W-2:0])));
  a_r2_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(word));
endmodule

// File: rtl/ssr_latch_bank.sv
module ssr_latch_bank
  import ssr_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int REF_W  = 17,
  parameter int MAIN_W = 14,
  parameter int SWAL_W = 4,
  localparam int WORD_W = DATA_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_evt,
  input  logic [WORD_W-1:0] word,
  output logic [REF_W-1:0]  ref_div,
  output logic [MAIN_W-1:0] main_cnt,
  output logic [SWAL_W-1:0] swal_cnt,
  output logic              ref_wr,
  output logic              cmp_wr
);
  dst_e              dst;
  logic [DATA_W-1:0] data;
  logic              ref_sel, cmp_sel;

  logic [REF_W-1:0]  ref_q, ref_d;
  logic [MAIN_W-1:0] main_q, main_d;
  logic [SWAL_W-1:0] swal_q, swal_d;
  logic              ref_wr_q, cmp_wr_q;

  assign dst  = dst_e'(word[ADDR_W-1:0]);
  assign data = word[WORD_W-1:ADDR_W];

  always_comb begin
    ref_sel = load_evt && (dst == DST_REF);
    cmp_sel = load_evt && (dst == DST_CMP);
    ref_d   = ref_q;
    main_d  = main_q;
    swal_d  = swal_q;
    if (ref_sel) ref_d = data[REF_W-1:0];
    if (cmp_sel) begin
      main_d = data[SWAL_W +: MAIN_W];
      swal_d = data[SWAL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q    <= '0;
      main_q   <= '0;
      swal_q   <= '0;
      ref_wr_q <= 1'b0;
      cmp_wr_q <= 1'b0;
    end else begin
      ref_q    <= ref_d;
      main_q   <= main_d;
      swal_q   <= swal_d;
      ref_wr_q <= ref_sel;
      cmp_wr_q <= cmp_sel;
    end
  end

  assign ref_div  = ref_q;
  assign main_cnt = main_q;
  assign swal_cnt = swal_q;
  assign ref_wr   = ref_wr_q;
  assign cmp_wr   = cmp_wr_q;

  a_r5_reject : assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !word[0]) |=> (!ref_wr && !cmp_wr && $stable(ref_div)
                                && $stable(main_cnt) && $stable(swal_cnt)));
  a_r6_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ref_wr, cmp_wr}));
  a_r6_one_cycle : assert property (@(posedge clk) disable iff (!rst_n)
    (ref_wr || cmp_wr) |=> (!ref_wr && !cmp_wr));
  a_r7_ref_guard : assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_div) |-> ref_wr);
  a_r7_cmp_guard : assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(main_cnt) || !$stable(swal_cnt)) |-> cmp_wr);
  a_r4_cmp_load : assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && word[1:0] == 2'b01) |=> ({main_cnt, swal_cnt} == $past(word[WORD_W-1:ADDR_W])));
endmodule

// File: rtl/synth_ser_ctrl.sv
module synth_ser_ctrl
  import ssr_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int REF_W  = 17,
  parameter int MAIN_W = 14,
  parameter int SWAL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ld_en,
  output logic [REF_W-1:0]  ref_div,
  output logic [MAIN_W-1:0] main_cnt,
  output logic [SWAL_W-1:0] swal_cnt,
  output logic              ref_wr,
  output logic              cmp_wr
);
  localparam int WORD_W = DATA_W + ADDR_W;
  localparam int NPIN   = 3;
  localparam int P_CLK  = 0;
  localparam int P_DAT  = 1;
  localparam int P_LD   = 2;

  logic            rst_m_q, rst_s_q;
  logic [NPIN-1:0] pin_lvl, pin_rise;
  logic [WORD_W-1:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  ssr_edge_sync #(.W(NPIN)) u_sync (
    .clk    (clk),
    .rst_n  (rst_s_q),
    .pin_in ({ld_en, ser_dat, ser_clk}),
    .level  (pin_lvl),
    .rise   (pin_rise)
  );

  ssr_shift #(.W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_s_q),
    .shift_en (pin_rise[P_CLK]),
    .bit_in   (pin_lvl[P_DAT]),
    .word     (word)
  );

  ssr_latch_bank #(
    .DATA_W (DATA_W),
    .REF_W  (REF_W),
    .MAIN_W (MAIN_W),
    .SWAL_W (SWAL_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_s_q),
    .load_evt (pin_rise[P_LD]),
    .word     (word),
    .ref_div  (ref_div),
    .main_cnt (main_cnt),
    .swal_cnt (swal_cnt),
    .ref_wr   (ref_wr),
    .cmp_wr   (cmp_wr)
  );

  // R1: outputs held at zero while the synchronized reset is active
  a_r1_reset_zero : assert property (@(posedge clk)
    !rst_s_q |-> (ref_div == '0 && main_cnt == '0 && swal_cnt == '0 && !ref_wr && !cmp_wr));
endmodule

// File: tb/synth_ser_ctrl_tb.sv
module synth_ser_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n, ser_clk, ser_dat, ld_en;
  logic [16:0] ref_div;
  logic [13:0] main_cnt;
  logic [3:0]  swal_cnt;
  logic ref_wr, cmp_wr;

  int checks = 0, failures = 0;
  int ref_pulses = 0, cmp_pulses = 0;
  bit done = 1'b0;
  logic [16:0] exp_ref  = '0;
  logic [13:0] exp_main = '0;
  logic [3:0]  exp_swal = '0;

  always #5 clk = ~clk;

  synth_ser_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ld_en(ld_en),
    .ref_div(ref_div), .main_cnt(main_cnt), .swal_cnt(swal_cnt),
    .ref_wr(ref_wr), .cmp_wr(cmp_wr)
  );

  always @(negedge clk) begin
    if (ref_wr) ref_pulses++;
    if (cmp_wr) cmp_pulses++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [17:0] d, input logic [1:0] a);
    logic [19:0] w = {d, a};
    for (int i = 19; i >= 0; i--) begin
      ser_dat = w[i];
      repeat (4) @(posedge clk);
      ser_clk = 1'b1;
      repeat (4) @(posedge clk);
      ser_clk = 1'b0;
    end
    repeat (4) @(posedge clk);
  endtask

  function automatic void model(input logic [17:0] d, input logic [1:0] a,
                                output int exp_r, output int exp_c);
    exp_r = 0;
    exp_c = 0;
    if (a == 2'b11) begin
      exp_ref = d[16:0];
      exp_r = 1;
    end else if (a == 2'b01) begin
      exp_main = d[17:4];
      exp_swal = d[3:0];
      exp_c = 1;
    end
  endfunction

  task automatic load_and_check(input logic [17:0] d, input logic [1:0] a, input int hold, input string tag);
    int r0, c0, er, ec;
    send_word(d, a);
    model(d, a, er, ec);
    r0 = ref_pulses;
    c0 = cmp_pulses;
    @(negedge clk);
    ld_en = 1'b1;
    // R8: new value visible after the third rising edge
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ref_div == exp_ref, {tag, " R8 ref"}, ref_div, exp_ref);
    chk({main_cnt, swal_cnt} == {exp_main, exp_swal}, {tag, " R8 cmp"}, {main_cnt, swal_cnt}, {exp_main, exp_swal});
    repeat (hold) @(posedge clk);
    ld_en = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(ref_div == exp_ref, {tag, " R3 R7 ref"}, ref_div, exp_ref);
    chk(main_cnt == exp_main, {tag, " R4 R7 main"}, main_cnt, exp_main);
    chk(swal_cnt == exp_swal, {tag, " R4 R7 swal"}, swal_cnt, exp_swal);
    chk(ref_pulses - r0 == er, {tag, " R6 ref pulses"}, ref_pulses - r0, er);
    chk(cmp_pulses - c0 == ec, {tag, " R5 R6 cmp pulses"}, cmp_pulses - c0, ec);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    rst_n = 1'b0; ser_clk = 1'b0; ser_dat = 1'b0; ld_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ref_div == 0 && main_cnt == 0 && swal_cnt == 0, "R1 outputs in reset", {ref_div, swal_cnt}, 0);
    chk(!ref_wr && !cmp_wr, "R1 pulses in reset", {ref_wr, cmp_wr}, 0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(ref_div == 0 && main_cnt == 0 && swal_cnt == 0, "R1 after release", {ref_div, swal_cnt}, 0);

    load_and_check(18'h2ABCD, 2'b11, 2, "dir_ref");
    load_and_check(18'h3FFFF, 2'b01, 2, "dir_cmp_ones");
    load_and_check(18'h3FFFF, 2'b11, 2, "dir_ref_ones");
    load_and_check(18'h20000, 2'b11, 2, "R3 lead_bit_ignored");
    load_and_check(18'h15555, 2'b00, 2, "R5 code00");
    load_and_check(18'h0AAAA, 2'b10, 2, "R5 code10");
    load_and_check(18'h12345, 2'b01, 40, "R6 long_hold");
    // R2: extra leading bits before the last 20 are pushed out
    send_word(18'h3FFFF, 2'b11);
    load_and_check(18'h00F0F, 2'b01, 2, "R2 overrun");

    for (int k = 0; k < 40; k++) begin
      logic [17:0] d = 18'($urandom);
      logic [1:0]  a = 2'($urandom);
      load_and_check(d, a, 1 + ($urandom % 5), "rnd");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule